// File: doc/BRIEF.md
# Windowed Bus Address Translator

This block converts addresses between a peripheral bus and the system address space. It works in both directions. A request that arrives from the bus is compared with one inbound window. The window size is a power of two and is set by a 3-bit size code. The window is split into eight equal slices with no further setup. Each slice has its own system base address, so a bus address inside the window becomes that slice's base plus the address's position within the slice. A bus address outside the window is dropped: it produces a miss and no translated address.

A request that travels from the system to the bus gets a single programmable offset added to it. An offset of zero leaves the address unchanged. The slice table is used only for inbound traffic, and the offset is used only for outbound traffic.

Both directions return their result one clock after the request. Software sets up the window base, the size code, the offset and the eight slice bases through a small write/read register port.

Top module: `bus_window_xlate`

## Requirements
- R1: After reset, `ib_out_valid`, `ib_hit` and `ob_out_valid` are low, and every configuration register reads 0.
- R2: Register addresses on `cfg_addr` are as follows.
  - 0 is the window base (32 bits).
  - 1 is the size code. Only bits [2:0] are stored, and the upper bits read 0.
  - 2 is the outbound offset (32 bits).
  - 8+k is the system base of slice k.
  - Addresses 3 to 7 read 0, and writes to them are ignored.
  - A write takes effect at the clock edge where `cfg_we` is high.
  - `cfg_rdata` shows the addressed register combinationally.
- R3: With size code i, the window covers 2^(23+i) bytes. A bus address hits when its bits at and above position 23+i equal the same bits of the window base.
- R4: On a miss, `ib_out_valid` is high while `ib_hit` is low and `ib_sys_addr` is 0.
- R5: For a hit, the slice number k is the three address bits [22+i:20+i], and slice k's base register is used.
- R6: For a hit, `ib_sys_addr` is slice k's base plus the address's low 20+i bits, modulo 2^32.
- R7: `ob_bus_addr` is `ob_sys_addr` plus the offset register, wrapping modulo 2^32. An offset of 0 gives the input unchanged.
- R8: The offset has no effect on inbound results, and the slice bases and window settings have no effect on outbound results.
- R9: Each direction registers its result once. The output valid equals the input valid one cycle earlier. When no request was made, `ib_hit` is low.
- R10: A request that arrives in the same cycle as a register write uses the old register value. The next request uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| ib_valid | input | 1 | Inbound request present |
| ib_addr | input | 32 | Inbound bus-side address |
| ib_out_valid | output | 1 | Inbound result present |
| ib_hit | output | 1 | Inbound address fell inside the window |
| ib_sys_addr | output | 32 | Translated system address (0 on miss) |
| ob_valid | input | 1 | Outbound request present |
| ob_sys_addr | input | 32 | Outbound system address |
| ob_out_valid | output | 1 | Outbound result present |
| ob_bus_addr | output | 32 | Translated bus-side address |

## Verification
The bench tests the edges of the window: the first and last byte inside it, and the bytes just below and just above it. A design with an off-by-one in its window mask would hit or miss on the wrong side of a boundary. It uses the smallest and the largest size codes, so a slice select taken from a fixed bit position would pick the wrong slice base. An outbound sum that crosses 2^32 catches any adder that saturates or keeps a carry. A slice base rewritten in the same cycle as a request shows whether the new value leaks into the request already in flight.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W      = 32;
  localparam int SIZE_BASE   = 23;
  localparam int CODE_W      = 3;
  localparam int SEL_W       = 3;
  localparam int NUM_SLICES  = 1 << SEL_W;
  localparam int CFG_AW      = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CODE_W-1:0] code_t;

  // log2 of the window size in bytes
  function automatic int unsigned win_log2(input code_t code);
    return SIZE_BASE + int'(code);
  endfunction

  // address falls inside the aligned window
  function automatic logic in_window(input addr_t addr, input addr_t base, input code_t code);
    addr_t hi_mask;
    hi_mask = ~((addr_t'(1) << win_log2(code)) - addr_t'(1));
    return ((addr ^ base) & hi_mask) == '0;
  endfunction

  // slice number: the SEL_W bits just under the window boundary
  function automatic logic [SEL_W-1:0] slice_of(input addr_t addr, input code_t code);
    addr_t sh;
    sh = addr >> (win_log2(code) - SEL_W);
    return sh[SEL_W-1:0];
  endfunction

  // position of the address inside its slice
  function automatic addr_t slice_offset(input addr_t addr, input code_t code);
    addr_t lo_mask;
    lo_mask = (addr_t'(1) << (win_log2(code) - SEL_W)) - addr_t'(1);
    return addr & lo_mask;
  endfunction

  function automatic addr_t wrap_add(input addr_t a, input addr_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import xlate_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int NSLICE = NUM_SLICES,
  parameter int CAW    = CFG_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [CAW-1:0]          addr,
  input  logic [AW-1:0]           wdata,
  output logic [AW-1:0]           rdata,
  output logic [AW-1:0]           win_base,
  output logic [CODE_W-1:0]       win_code,
  output logic [AW-1:0]           ob_offset,
  output logic [NSLICE-1:0][AW-1:0] slice_base
);
  localparam logic [CAW-1:0] SEL_BASE   = CAW'(0);
  localparam logic [CAW-1:0] SEL_CODE   = CAW'(1);
  localparam logic [CAW-1:0] SEL_OFFSET = CAW'(2);
  localparam int             BANK_BIT   = CAW - 1;

  logic wr_base, wr_code, wr_offset, bank_hit;
  assign bank_hit  = addr[BANK_BIT];
  assign wr_base   = we && (addr == SEL_BASE);
  assign wr_code   = we && (addr == SEL_CODE);
  assign wr_offset = we && (addr == SEL_OFFSET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_base  <= '0;
      win_code  <= '0;
      ob_offset <= '0;
    end else begin
      if (wr_base)   win_base  <= wdata;
      if (wr_code)   win_code  <= wdata[CODE_W-1:0];
      if (wr_offset) ob_offset <= wdata;
    end
  end

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    logic wr_k;
    assign wr_k = we && bank_hit && (addr[BANK_BIT-1:0] == (BANK_BIT)'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)    slice_base[k] <= '0;
      else if (wr_k) slice_base[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (bank_hit) begin
      rdata = slice_base[addr[BANK_BIT-1:0]];
    end else begin
      case (addr)
        SEL_BASE:   rdata = win_base;
        SEL_CODE:   rdata = AW'(win_code);
        SEL_OFFSET: rdata = ob_offset;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/xlate_inbound.sv
module xlate_inbound
  import xlate_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int NSLICE = NUM_SLICES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [AW-1:0]             req_addr,
  input  logic [AW-1:0]             win_base,
  input  logic [CODE_W-1:0]         win_code,
  input  logic [NSLICE-1:0][AW-1:0] slice_base,
  output logic                      hit_now,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [AW-1:0]             rsp_addr
);
  logic [SEL_W-1:0] sel;
  logic [AW-1:0]    sys_now;

  assign hit_now = req_valid && in_window(req_addr, win_base, win_code);
  assign sel     = slice_of(req_addr, win_code);
  assign sys_now = wrap_add(slice_base[sel], slice_offset(req_addr, win_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= hit_now;
      rsp_addr  <= hit_now ? sys_now : '0;
    end
  end
endmodule

// File: rtl/xlate_outbound.sv
module xlate_outbound
  import xlate_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] offset,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_addr <= wrap_add(req_addr, offset);
    end
  end
endmodule

// File: rtl/bus_window_xlate.sv
module bus_window_xlate
  import xlate_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int CAW = CFG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  cfg_rdata,
  input  logic           ib_valid,
  input  logic [AW-1:0]  ib_addr,
  output logic           ib_out_valid,
  output logic           ib_hit,
  output logic [AW-1:0]  ib_sys_addr,
  input  logic           ob_valid,
  input  logic [AW-1:0]  ob_sys_addr,
  output logic           ob_out_valid,
  output logic [AW-1:0]  ob_bus_addr
);
  logic [AW-1:0]                 win_base;
  logic [CODE_W-1:0]             win_code;
  logic [AW-1:0]                 ob_offset;
  logic [NUM_SLICES-1:0][AW-1:0] slice_base;
  logic                          ib_hit_now;

  xlate_cfg_regs #(.AW(AW), .NSLICE(NUM_SLICES), .CAW(CAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .win_base(win_base), .win_code(win_code),
    .ob_offset(ob_offset), .slice_base(slice_base)
  );

  xlate_inbound #(.AW(AW), .NSLICE(NUM_SLICES)) u_in (
    .clk(clk), .rst_n(rst_n), .req_valid(ib_valid), .req_addr(ib_addr),
    .win_base(win_base), .win_code(win_code), .slice_base(slice_base),
    .hit_now(ib_hit_now), .rsp_valid(ib_out_valid), .rsp_hit(ib_hit),
    .rsp_addr(ib_sys_addr)
  );

  xlate_outbound #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .req_valid(ob_valid), .req_addr(ob_sys_addr),
    .offset(ob_offset), .rsp_valid(ob_out_valid), .rsp_addr(ob_bus_addr)
  );
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker
  import xlate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ib_valid,
  input logic [ADDR_W-1:0] ib_addr,
  input logic              ib_out_valid,
  input logic              ib_hit,
  input logic [ADDR_W-1:0] ib_sys_addr,
  input logic              ob_valid,
  input logic [ADDR_W-1:0] ob_sys_addr,
  input logic              ob_out_valid,
  input logic [ADDR_W-1:0] ob_bus_addr,
  input logic [ADDR_W-1:0] win_base,
  input logic [CODE_W-1:0] win_code,
  input logic [ADDR_W-1:0] ob_offset
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid |=> ib_out_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ib_valid |=> (!ib_out_valid && !ib_hit));

  assert_miss_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_out_valid && !ib_hit) |-> (ib_sys_addr == '0));

  assert_hit_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid |=> (ib_hit == ((($past(ib_addr) ^ $past(win_base))
                  >> (SIZE_BASE + int'($past(win_code)))) == '0)));

  assert_outbound_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid |=> (ob_out_valid && ob_bus_addr == ADDR_W'($past(ob_sys_addr) + $past(ob_offset))));
endmodule

bind bus_window_xlate xlate_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ib_valid(ib_valid), .ib_addr(ib_addr),
  .ib_out_valid(ib_out_valid), .ib_hit(ib_hit), .ib_sys_addr(ib_sys_addr),
  .ob_valid(ob_valid), .ob_sys_addr(ob_sys_addr), .ob_out_valid(ob_out_valid),
  .ob_bus_addr(ob_bus_addr), .win_base(win_base), .win_code(win_code),
  .ob_offset(ob_offset)
);

// File: tb/bus_window_xlate_tb.sv
module bus_window_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ib_valid = 1'b0;
  logic [31:0] ib_addr = '0;
  logic        ib_out_valid, ib_hit;
  logic [31:0] ib_sys_addr;
  logic        ob_valid = 1'b0;
  logic [31:0] ob_sys_addr = '0;
  logic        ob_out_valid;
  logic [31:0] ob_bus_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_window_xlate u_dut (.*);

  // {address, expected hit, expected system address}; window code 1, base 0x4000_0000,
  // slice k base 0x8000_0000 + k*0x0100_0000
  localparam int NV = 8;
  localparam logic [64:0] VEC [NV] = '{
    {32'h4000_0000, 1'b1, 32'h8000_0000},
    {32'h4020_0010, 1'b1, 32'h8100_0010},
    {32'h40FF_FFFF, 1'b1, 32'h871F_FFFF},
    {32'h4100_0000, 1'b0, 32'h0000_0000},
    {32'h3FFF_FFFC, 1'b0, 32'h0000_0000},
    {32'h4070_1234, 1'b1, 32'h8310_1234},
    {32'h40A0_0000, 1'b1, 32'h8500_0000},
    {32'hC000_0000, 1'b0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic inb(input string req, input logic [31:0] a, input logic eh, input logic [31:0] ea);
    @(negedge clk);
    ib_valid = 1'b1; ib_addr = a;
    @(negedge clk);
    ib_valid = 1'b0;
    chk(req, {31'b0, ib_out_valid}, 32'd1);
    chk(req, {31'b0, ib_hit}, {31'b0, eh});
    chk(req, ib_sys_addr, ea);
  endtask

  task automatic outb(input string req, input logic [31:0] a, input logic [31:0] ea);
    @(negedge clk);
    ob_valid = 1'b1; ob_sys_addr = a;
    @(negedge clk);
    ob_valid = 1'b0;
    chk(req, {31'b0, ob_out_valid}, 32'd1);
    chk(req, ob_bus_addr, ea);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ib_out_valid", {31'b0, ib_out_valid}, 32'd0);
    chk("R1 ib_hit", {31'b0, ib_hit}, 32'd0);
    chk("R1 ob_out_valid", {31'b0, ob_out_valid}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) rd_chk("R1 reg reset", 4'(a), 32'd0);

    // R3 R5 R6 smallest window at base 0 (reset state), slice 7 base programmed
    wr(4'd15, 32'h9000_0000);
    inb("R5 code0 top slice", 32'h007F_FFFF, 1'b1, 32'h900F_FFFF);
    inb("R3 code0 just above", 32'h0080_0000, 1'b0, 32'h0);

    // R2 configuration and read back
    wr(4'd0, 32'h4000_0000);
    wr(4'd1, 32'hFFFF_FFF9);
    rd_chk("R2 code masked", 4'd1, 32'd1);
    wr(4'd5, 32'hDEAD_BEEF);
    rd_chk("R2 hole reads zero", 4'd5, 32'd0);
    rd_chk("R2 base readback", 4'd0, 32'h4000_0000);
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'h8000_0000 + 32'(k) * 32'h0100_0000);
    rd_chk("R2 slice readback", 4'd11, 32'h8300_0000);

    // R3 R4 R5 R6 table
    for (int v = 0; v < NV; v++) begin
      inb("R3/R4/R5/R6 table", VEC[v][64:33], VEC[v][32], VEC[v][31:0]);
    end

    // R9: idle cycle gives no output
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle valid", {31'b0, ib_out_valid}, 32'd0);
    chk("R9 idle hit", {31'b0, ib_hit}, 32'd0);

    // R7 outbound identity, then wrap
    outb("R7 identity", 32'h1234_5678, 32'h1234_5678);
    wr(4'd2, 32'h1000_0000);
    outb("R7 wrap", 32'hF800_0000, 32'h0800_0000);
    // R8 offset does not touch inbound; slice bases do not touch outbound
    inb("R8 inbound unaffected", 32'h4020_0010, 1'b1, 32'h8100_0010);
    wr(4'd9, 32'h0000_0000);
    wr(4'd0, 32'h0);
    outb("R8 outbound unaffected", 32'h0000_0100, 32'h1000_0100);

    // R10 largest window; slice base written in same cycle as request
    wr(4'd0, 32'hC000_0000);
    wr(4'd1, 32'd7);
    wr(4'd10, 32'h8000_0000);
    @(negedge clk);
    ib_valid = 1'b1; ib_addr = 32'hD234_5678;
    cfg_we = 1'b1; cfg_addr = 4'd10; cfg_wdata = 32'h1000_0000;
    @(negedge clk);
    ib_valid = 1'b0; cfg_we = 1'b0;
    chk("R10 old value used", ib_sys_addr, 32'h8234_5678);
    inb("R10 new value used", 32'hD234_5678, 1'b1, 32'h1234_5678);
    inb("R3 code7 below", 32'hBFFF_FFFF, 1'b0, 32'h0);
    inb("R5 code7 slice 0", 32'hC000_0004, 1'b1, 32'h8000_0004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule